// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue. It turns one two-source add that looks like a scalar instruction into a loop over up to `MAX_VL` elements, all on one shared integer register file. The register file itself lives outside the block. The sequencer drives two read addresses, receives the read data on the same cycle, and drives a single write port. It signals `done` only once the whole loop has finished, which is the point where the caller may advance to the next instruction.

Each of the three operands carries its own scalar/vector flag:

- A vector operand steps to the next register number on every element.
- A scalar operand stays on its base register.

A predicate mask selects which elements produce a result. Masked elements still advance every operand. In zeroing mode a masked element clears its destination register; otherwise the destination is left alone. A scalar destination ends the loop at its first write. Together with leading zero mask bits, this lets a scalar destination pick one element out of a vector source.

One element is handled per clock. Read addresses come straight from flops. The write for an element lands on the clock edge that ends that element's cycle, so the next element already reads the updated register file.

Top module: `vec_loop_seq`

## Requirements
- R1: After `start` is accepted with VL = n (1..MAX_VL), exactly n element cycles follow. `done` is high for one cycle, in the cycle after the last element, with `busy` low. A VL above MAX_VL is treated as MAX_VL.
- R2: A source flagged vector reads register base+i for element i, with register numbers wrapping modulo 2^AREG_W. A source flagged scalar reads its base register for every element.
- R3: With a vector destination, the result of element i goes to register dst_base+i (wrapping). Each element reads the register file as left by all earlier elements.
- R4: With a scalar destination, the loop ends in the cycle of its first write to the register file, and `done` follows in the next cycle.
- R5: When bit i of `pred_mask` is 0 and zeroing is off, element i writes nothing, but all operand register numbers still advance.
- R6: When `pred_en` is 0, the mask is taken as all ones. When `pred_en` is 1, bit i of `pred_mask` (bit 0 = element 0) governs element i.
- R7: With `zero_mode` = 1, a masked element writes 0 to its destination register. With a scalar destination, that zero write ends the loop.
- R8: `start` with VL = 0 raises `done` in the next cycle, with no register writes and `busy` staying low.
- R9: A `start` that arrives while `busy` is high is ignored. The running loop and its results are unaffected.
- R10: During and right after reset, `busy`, `done` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one operation (ignored while busy) |
| vl | input | VL_W | Element count |
| dst_base | input | AREG_W | Destination base register |
| dst_vec | input | 1 | Destination is a vector |
| srca_base | input | AREG_W | First source base register |
| srca_vec | input | 1 | First source is a vector |
| srcb_base | input | AREG_W | Second source base register |
| srcb_vec | input | 1 | Second source is a vector |
| pred_en | input | 1 | Use pred_mask (0 = all elements active) |
| pred_mask | input | MAX_VL | Per-element enable, bit i for element i |
| zero_mode | input | 1 | Masked elements write zero |
| rd_addr_a | output | AREG_W | First source read address |
| rd_addr_b | output | AREG_W | Second source read address |
| rd_data_a | input | DATA_W | First source read data (same cycle) |
| rd_data_b | input | DATA_W | Second source read data (same cycle) |
| wr_addr | output | AREG_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_en | output | 1 | Write strobe, taken at the rising edge |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check:

- how each read address and the write address move between consecutive busy cycles, stepping by one or holding according to the latched flags;
- that writes occur only while busy;
- that `done` never overlaps `busy`;
- that a scalar-destination write ends the loop.

Only the bench scenarios can show the actual register-file contents. That covers the sums landing in the right registers, zeros against untouched registers under masking, reads seeing earlier elements' writes, the exact element-cycle count, VL clamping and the rejection of an intruding `start`.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int NUM_OPNDS = 3;
  localparam int OPND_DST  = 0;
  localparam int OPND_SRCA = 1;
  localparam int OPND_SRCB = 2;
endpackage

// File: rtl/vls_idx_ctr.sv
module vls_idx_ctr #(
  parameter int AREG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [AREG_W-1:0] base_in,
  input  logic              vec_in,
  output logic [AREG_W-1:0] addr,
  output logic              vec_q
);
  // Register number for one operand: latched on launch, stepped per element
  // only when the operand was flagged as a vector.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      vec_q <= 1'b0;
    end else if (load) begin
      addr  <= base_in;
      vec_q <= vec_in;
    end else if (step && vec_q) begin
      addr  <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/vls_elem_ctl.sv
module vls_elem_ctl #(
  parameter int MAX_VL = 8,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [VL_W-1:0]   vl_in,
  input  logic              pred_en,
  input  logic [MAX_VL-1:0] pred_mask,
  input  logic              zero_in,
  output logic              last,
  output logic              pred_bit,
  output logic              zero_q
);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  logic [VL_W-1:0]   idx_q;
  logic [VL_W-1:0]   len_q;
  logic [MAX_VL-1:0] mask_q;
  logic [MAX_VL-1:0] mask_sh;
  logic [VL_W-1:0]   vl_eff;

  assign vl_eff = (vl_in > VL_CAP) ? VL_CAP : vl_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      len_q  <= '0;
      mask_q <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      idx_q  <= '0;
      len_q  <= vl_eff;
      mask_q <= pred_en ? pred_mask : '1;
      zero_q <= zero_in;
    end else if (step) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign mask_sh  = mask_q >> idx_q;
  assign pred_bit = mask_sh[0];
  assign last     = (idx_q == (len_q - 1'b1));
endmodule

// File: rtl/vls_alu.sv
module vls_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              pred_bit,
  input  logic              zero_mode,
  output logic              wr_req,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] sum;

  assign sum    = opa + opb;
  assign wr_req = pred_bit | zero_mode;
  assign res    = pred_bit ? sum : '0;
endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq
  import vls_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AREG_W = 5,
  parameter int MAX_VL = 8,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [AREG_W-1:0] dst_base,
  input  logic              dst_vec,
  input  logic [AREG_W-1:0] srca_base,
  input  logic              srca_vec,
  input  logic [AREG_W-1:0] srcb_base,
  input  logic              srcb_vec,
  input  logic              pred_en,
  input  logic [MAX_VL-1:0] pred_mask,
  input  logic              zero_mode,
  output logic [AREG_W-1:0] rd_addr_a,
  output logic [AREG_W-1:0] rd_addr_b,
  input  logic [DATA_W-1:0] rd_data_a,
  input  logic [DATA_W-1:0] rd_data_b,
  output logic [AREG_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              busy,
  output logic              done
);
  seq_state_e state_q;
  logic       done_q;
  logic       accept;
  logic       finish;
  logic       adv;
  logic       vl_zero;
  logic       last;
  logic       pred_bit;
  logic       zero_q;
  logic       wr_req;

  logic [NUM_OPNDS-1:0][AREG_W-1:0] base_all;
  logic [NUM_OPNDS-1:0][AREG_W-1:0] addr_all;
  logic [NUM_OPNDS-1:0]             vec_in;
  logic [NUM_OPNDS-1:0]             vec_q;
  logic                             dst_vec_q;
  logic                             srca_vec_q;
  logic                             srcb_vec_q;

  assign base_all[OPND_DST]  = dst_base;
  assign base_all[OPND_SRCA] = srca_base;
  assign base_all[OPND_SRCB] = srcb_base;
  assign vec_in[OPND_DST]    = dst_vec;
  assign vec_in[OPND_SRCA]   = srca_vec;
  assign vec_in[OPND_SRCB]   = srcb_vec;

  assign busy    = (state_q == SEQ_RUN);
  assign accept  = start && !busy;
  assign vl_zero = (vl == '0);

  // One operand counter per register operand.
  for (genvar k = 0; k < NUM_OPNDS; k++) begin : g_opnd
    vls_idx_ctr #(.AREG_W(AREG_W)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .step    (adv),
      .base_in (base_all[k]),
      .vec_in  (vec_in[k]),
      .addr    (addr_all[k]),
      .vec_q   (vec_q[k])
    );
  end

  assign dst_vec_q  = vec_q[OPND_DST];
  assign srca_vec_q = vec_q[OPND_SRCA];
  assign srcb_vec_q = vec_q[OPND_SRCB];

  vls_elem_ctl #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_elem (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .step      (adv),
    .vl_in     (vl),
    .pred_en   (pred_en),
    .pred_mask (pred_mask),
    .zero_in   (zero_mode),
    .last      (last),
    .pred_bit  (pred_bit),
    .zero_q    (zero_q)
  );

  vls_alu #(.DATA_W(DATA_W)) u_alu (
    .opa       (rd_data_a),
    .opb       (rd_data_b),
    .pred_bit  (pred_bit),
    .zero_mode (zero_q),
    .wr_req    (wr_req),
    .res       (wr_data)
  );

  // Loop ends on the last element, or on the first write to a scalar destination.
  assign finish = busy && (last || (!dst_vec_q && wr_req));
  assign adv    = busy && !finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= (accept && vl_zero) || finish;
      if (accept && !vl_zero) begin
        state_q <= SEQ_RUN;
      end else if (finish) begin
        state_q <= SEQ_IDLE;
      end
    end
  end

  assign rd_addr_a = addr_all[OPND_SRCA];
  assign rd_addr_b = addr_all[OPND_SRCB];
  assign wr_addr   = addr_all[OPND_DST];
  assign wr_en     = busy && wr_req;
  assign done      = done_q;
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
  parameter int AREG_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [AREG_W-1:0] rd_addr_a,
  input logic [AREG_W-1:0] rd_addr_b,
  input logic [AREG_W-1:0] wr_addr,
  input logic              dst_vec_q,
  input logic              srca_vec_q,
  input logic              srcb_vec_q
);
  a_r10_write_only_busy: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  a_r1_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r2_srca_vec_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && srca_vec_q) |-> (rd_addr_a == $past(rd_addr_a) + 1'b1));

  a_r2_srca_scalar_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !srca_vec_q) |-> $stable(rd_addr_a));

  a_r2_srcb_vec_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && srcb_vec_q) |-> (rd_addr_b == $past(rd_addr_b) + 1'b1));

  a_r2_srcb_scalar_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !srcb_vec_q) |-> $stable(rd_addr_b));

  a_r3_dst_vec_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && dst_vec_q) |-> (wr_addr == $past(wr_addr) + 1'b1));

  a_r4_scalar_dst_stops: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !dst_vec_q) |=> !busy);

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(dst_vec_q) && $stable(srca_vec_q) && $stable(srcb_vec_q)));
endmodule

bind vec_loop_seq vls_checker #(.AREG_W(AREG_W)) u_vls_checker (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .wr_en      (wr_en),
  .rd_addr_a  (rd_addr_a),
  .rd_addr_b  (rd_addr_b),
  .wr_addr    (wr_addr),
  .dst_vec_q  (dst_vec_q),
  .srca_vec_q (srca_vec_q),
  .srcb_vec_q (srcb_vec_q)
);

// File: tb/tb_vec_loop_seq.sv
module tb_vec_loop_seq;
  localparam int DATA_W = 16;
  localparam int AREG_W = 5;
  localparam int MAX_VL = 8;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int NREGS  = 1 << AREG_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [VL_W-1:0]   vl = '0;
  logic [AREG_W-1:0] dst_base = '0, srca_base = '0, srcb_base = '0;
  logic              dst_vec = 1'b0, srca_vec = 1'b0, srcb_vec = 1'b0;
  logic              pred_en = 1'b0;
  logic [MAX_VL-1:0] pred_mask = '0;
  logic              zero_mode = 1'b0;
  logic [AREG_W-1:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [DATA_W-1:0] rd_data_a, rd_data_b, wr_data;
  logic              wr_en, busy, done;

  logic [DATA_W-1:0] rf     [NREGS];
  logic [DATA_W-1:0] exp_rf [NREGS];

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk; // 50 MHz

  vec_loop_seq #(.DATA_W(DATA_W), .AREG_W(AREG_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) dut (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .dst_base(dst_base), .dst_vec(dst_vec),
    .srca_base(srca_base), .srca_vec(srca_vec),
    .srcb_base(srcb_base), .srcb_vec(srcb_vec),
    .pred_en(pred_en), .pred_mask(pred_mask), .zero_mode(zero_mode),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .busy(busy), .done(done)
  );

  // Register file model: same-cycle read, write at the rising edge.
  assign rd_data_a = rf[rd_addr_a];
  assign rd_data_b = rf[rd_addr_b];
  always @(posedge clk) begin
    if (wr_en) rf[wr_addr] <= wr_data;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [AREG_W-1:0] db, input bit dv,
                        input logic [AREG_W-1:0] ab, input bit av,
                        input logic [AREG_W-1:0] bb, input bit bv,
                        input bit pen, input logic [MAX_VL-1:0] m,
                        input bit zm, input int vl_i, input int seed,
                        input bit intrude, input string lab);
    logic [AREG_W-1:0] ia, ib, id;
    int n, len, cnt, mism, first_bad;
    bit p;
    // Fresh register-file contents and the expected result of the loop.
    for (int r = 0; r < NREGS; r++) begin
      rf[r]     = DATA_W'(r * 401 + seed * 13 + 7);
      exp_rf[r] = DATA_W'(r * 401 + seed * 13 + 7);
    end
    ia = ab; ib = bb; id = db; n = 0;
    len = (vl_i > MAX_VL) ? MAX_VL : vl_i;
    for (int i = 0; i < len; i++) begin
      p = pen ? m[i] : 1'b1;
      n = i + 1;
      if (p) exp_rf[id] = exp_rf[ia] + exp_rf[ib];
      else if (zm) exp_rf[id] = '0;
      if (!dv && (p || zm)) break;
      if (av) ia = ia + 1'b1;
      if (bv) ib = ib + 1'b1;
      if (dv) id = id + 1'b1;
    end
    dst_base = db; dst_vec = dv; srca_base = ab; srca_vec = av;
    srcb_base = bb; srcb_vec = bv; pred_en = pen; pred_mask = m;
    zero_mode = zm; vl = VL_W'(vl_i); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 40) begin
      if (intrude && cnt == 1) begin
        // R9: second launch with a different configuration while busy
        start = 1'b1; dst_base = db + 5'd9; dst_vec = 1'b1; vl = VL_W'(3);
        pred_en = 1'b0; zero_mode = 1'b1;
      end
      if (intrude && cnt == 2) start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    check(cnt == n, intrude ? "R9" : "R1", {lab, " element cycles"}, cnt, n);
    check(busy == 1'b0, "R1", {lab, " busy with done"}, busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R1", {lab, " done single pulse"}, done, 0);
    mism = 0; first_bad = -1;
    for (int r = 0; r < NREGS; r++) begin
      if (rf[r] !== exp_rf[r]) begin
        mism++;
        if (first_bad < 0) first_bad = r;
      end
    end
    if (first_bad < 0)
      check(1'b1, lab, "regfile", 0, 0);
    else
      check(1'b0, lab, $sformatf("regfile reg%0d", first_bad),
            rf[first_bad], exp_rf[first_bad]);
  endtask

  initial begin
    string lab;
    logic [MAX_VL-1:0] masks [4];
    int vls [3];
    int seed;
    masks[0] = 8'hFF; masks[1] = 8'b1011_0010; masks[2] = 8'b0000_0100; masks[3] = 8'h00;
    vls[0] = 1; vls[1] = 5; vls[2] = 8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);
    check(done == 1'b0, "R10", "done after reset", done, 0);
    check(wr_en == 1'b0, "R10", "wr_en after reset", wr_en, 0);
    seed = 0;
    // Sweep of operand flags, masks, zeroing and lengths; R2 covers mixed source flags.
    for (int f = 0; f < 8; f++) begin
      for (int z = 0; z < 2; z++) begin
        for (int mi = 0; mi < 4; mi++) begin
          for (int li = 0; li < 3; li++) begin
            seed++;
            if (f[0] == 1'b0) lab = (z == 1 && mi != 0) ? "R7" : "R4";
            else if (mi == 0) lab = "R6";
            else if (z == 1) lab = "R7";
            else lab = "R5";
            if (f[1] != f[2]) lab = {lab, "/R2"};
            else if (f[0] == 1'b1 && mi == 0) lab = {lab, "/R3"};
            run_op(AREG_W'(seed * 7), f[0], AREG_W'(seed * 3 + 1), f[1],
                   AREG_W'(seed * 5 + 2), f[2], mi != 0, masks[mi], z[0],
                   vls[li], seed, 1'b0, lab);
          end
        end
      end
    end
    // R3: overlapping vector source one register behind destination (chained reads)
    run_op(5'd4, 1'b1, 5'd3, 1'b1, 5'd20, 1'b0, 1'b0, 8'hFF, 1'b0, 6, 500, 1'b0, "R3");
    // R2: wrap of register numbers past the top of the file
    run_op(5'd29, 1'b1, 5'd30, 1'b1, 5'd31, 1'b1, 1'b0, 8'hFF, 1'b0, 8, 501, 1'b0, "R2");
    // R8: zero length
    run_op(5'd2, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 1'b0, 8'hFF, 1'b1, 0, 502, 1'b0, "R8");
    // R1: length beyond MAX_VL clamps
    run_op(5'd10, 1'b1, 5'd0, 1'b1, 5'd16, 1'b1, 1'b0, 8'hFF, 1'b0, 13, 503, 1'b0, "R1");
    // R4: scalar destination with leading masked elements selects one source element
    run_op(5'd1, 1'b0, 5'd8, 1'b1, 5'd24, 1'b0, 1'b1, 8'b0010_0000, 1'b0, 8, 504, 1'b0, "R4");
    // R9: start while busy is ignored
    run_op(5'd12, 1'b1, 5'd2, 1'b1, 5'd22, 1'b1, 1'b1, 8'b1101_1011, 1'b0, 6, 505, 1'b1, "R9");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule